// File: doc/BRIEF.md
# Load-Level Clock Operating Point Controller

This block chooses the operating point of a processor clock out of four load levels. Level 0 is the fastest and level 3 the slowest. Each level owns a configuration slot that holds a 2-bit source select, a clock select bit and a 3-bit divider. A 2-bit current-level register picks which slot drives the outputs.

When dynamic scaling is switched off, a static set of source, divider and clock select values drives the outputs instead. Software asks for a rate by giving a target divider. The controller searches the slots for a level whose divider matches and switches to that level. A switch into level 0 from level 2 or level 3 is never made in one step. The controller first moves to level 1 and holds there for a programmable settle time, so that the supply can rise, and only then enters level 0. Voltage regulation and the clock generator itself are outside this block.

Top module: `dvfs_level_ctrl`

## Requirements
- R1: After reset the current level is 0, busy is low, dynamic scaling is off, the driven source, divider and clock select are all zero, and no result pulse is high.
- R2: A write to address 0 loads the slot word for levels 0 and 1, and a write to address 1 loads the word for levels 2 and 3. In each word the even level occupies bits 31:16 and the odd level occupies bits 15:0. Within a 16-bit half, the source is at bits 10:9, the clock select at bit 11 and the divider at bits 15:13.
- R3: Bit 31 of a write to address 2 sets dynamic scaling on or off. While it is on, the outputs show the current level's slot. While it is off, the outputs show the static fields from address 3: source at bits 1:0, divider at bits 6:4 and clock select at bit 8.
- R4: A rate request with scaling on searches levels 0 to 3 in that order and takes the first level whose divider equals the request. One cycle later, rate_ok pulses for one cycle and the new level is in place.
- R5: A rate request that matches no slot, or that arrives while scaling is off, pulses rate_err for one cycle and leaves the level unchanged.
- R6: A source request while scaling is off writes the requested source into all four slots. The dividers and clock selects are left unchanged, and no error is raised.
- R7: A source request while scaling is on pulses src_err for one cycle and leaves every slot unchanged.
- R8: A matched request for level 0 while the level is 2 or 3 moves to level 1 in the next cycle. Busy is then held high for settle_cycles+1 cycles with level 1 in place. After that, level 0 is applied and busy falls in the same cycle.
- R9: While busy is high, rate and source requests are ignored: no pulse is raised and the level does not change.
- R10: Every other accepted switch, including a switch from level 1 to level 0, completes in one cycle without raising busy. With no request, the level holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0: levels 0/1, 1: levels 2/3, 2: mode, 3: static fields |
| cfg_wdata | input | 32 | Configuration write data |
| rate_req | input | 1 | Rate request strobe |
| rate_div | input | 3 | Target divider of the rate request |
| src_req | input | 1 | Source change request strobe |
| src_val | input | 2 | Requested source select |
| settle_cycles | input | CNT_W | Settle length in cycles, sampled when the stepped switch starts |
| cur_level | output | 2 | Current load level |
| busy | output | 1 | Stepped switch into level 0 in progress |
| dyn_en | output | 1 | Dynamic scaling enabled |
| clk_src | output | 2 | Driven source select |
| clk_csel | output | 1 | Driven clock select |
| clk_div | output | 3 | Driven divider |
| rate_ok | output | 1 | One-cycle pulse: rate request accepted |
| rate_err | output | 1 | One-cycle pulse: rate request rejected |
| src_err | output | 1 | One-cycle pulse: source request rejected |

## Verification
A corrupted slot word or a wrong half-word offset shows up as a wrong clk_src, clk_div or clk_csel in the first cycle that level is current. A fault in the search shows up at the next rate request, as the wrong level or a wrong ok/error pulse. A settle counter that is off by one moves the fall of busy and the entry into level 0 by exactly one cycle, so the bench counts busy cycles against settle_cycles+1. A broadcast of the source to the wrong slots stays hidden until a later request visits the damaged level, so the randomized run keeps moving across all four levels after each source change.

// File: rtl/dvfs_level_ctrl.sv
module dvfs_level_ctrl #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             rate_req,
  input  logic [2:0]       rate_div,
  input  logic             src_req,
  input  logic [1:0]       src_val,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic [1:0]       cur_level,
  output logic             busy,
  output logic             dyn_en,
  output logic [1:0]       clk_src,
  output logic             clk_csel,
  output logic [2:0]       clk_div,
  output logic             rate_ok,
  output logic             rate_err,
  output logic             src_err
);
  localparam int LEVELS   = 4;
  localparam int SRC_LSB  = 9;
  localparam int CSEL_BIT = 11;
  localparam int DIV_LSB  = 13;
  localparam int EVEN_OFS = 16;
  localparam int DYN_BIT  = 31;

  logic [31:0]      pair_q [2];
  logic [1:0]       stat_src;
  logic [2:0]       stat_div;
  logic             stat_csel;
  logic [CNT_W-1:0] wait_cnt;

  logic [2:0] lvl_div  [LEVELS];
  logic [1:0] lvl_src  [LEVELS];
  logic       lvl_csel [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_slot
    localparam int OFS = (g % 2 == 0) ? EVEN_OFS : 0;
    assign lvl_div[g]  = pair_q[g/2][OFS+DIV_LSB +: 3];
    assign lvl_src[g]  = pair_q[g/2][OFS+SRC_LSB +: 2];
    assign lvl_csel[g] = pair_q[g/2][OFS+CSEL_BIT];
  end

  logic       hit;
  logic [1:0] hit_lvl;
  always_comb begin
    hit = 1'b0;
    hit_lvl = 2'd0;
    for (int i = LEVELS-1; i >= 0; i--) begin
      if (lvl_div[i] == rate_div) begin
        hit = 1'b1;
        hit_lvl = 2'(i);
      end
    end
  end

  assign clk_src  = dyn_en ? lvl_src[cur_level]  : stat_src;
  assign clk_div  = dyn_en ? lvl_div[cur_level]  : stat_div;
  assign clk_csel = dyn_en ? lvl_csel[cur_level] : stat_csel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q[0] <= '0;
      pair_q[1] <= '0;
      stat_src  <= '0;
      stat_div  <= '0;
      stat_csel <= 1'b0;
      dyn_en    <= 1'b0;
      cur_level <= 2'd0;
      busy      <= 1'b0;
      wait_cnt  <= '0;
      rate_ok   <= 1'b0;
      rate_err  <= 1'b0;
      src_err   <= 1'b0;
    end else begin
      rate_ok  <= 1'b0;
      rate_err <= 1'b0;
      src_err  <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: pair_q[0] <= cfg_wdata;
          2'd1: pair_q[1] <= cfg_wdata;
          2'd2: dyn_en <= cfg_wdata[DYN_BIT];
          default: begin
            stat_src  <= cfg_wdata[1:0];
            stat_div  <= cfg_wdata[6:4];
            stat_csel <= cfg_wdata[8];
          end
        endcase
      end
      if (src_req && !busy) begin
        if (dyn_en) src_err <= 1'b1;
        else begin
          for (int p = 0; p < 2; p++) begin
            pair_q[p][SRC_LSB +: 2]          <= src_val;
            pair_q[p][EVEN_OFS+SRC_LSB +: 2] <= src_val;
          end
        end
      end
      if (busy) begin
        if (wait_cnt == '0) begin
          cur_level <= 2'd0;
          busy      <= 1'b0;
        end else begin
          wait_cnt <= wait_cnt - 1'b1;
        end
      end else if (rate_req) begin
        if (!dyn_en || !hit) begin
          rate_err <= 1'b1;
        end else begin
          rate_ok <= 1'b1;
          if (hit_lvl == 2'd0 && cur_level[1]) begin
            cur_level <= 2'd1;
            busy      <= 1'b1;
            wait_cnt  <= settle_cycles;
          end else begin
            cur_level <= hit_lvl;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dvfs_level_ctrl_chk.sv
module dvfs_level_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rate_req,
  input logic       src_req,
  input logic [1:0] cur_level,
  input logic       busy,
  input logic       dyn_en,
  input logic       rate_ok,
  input logic       rate_err,
  input logic       src_err
);
  a_r8_busy_at_level1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cur_level == 2'd1);
  a_r8_exit_to_level0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cur_level == 2'd0);
  a_r8_entry_from_slow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cur_level[1]));
  a_r9_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rate_ok && !rate_err && !src_err);
  a_r5_ok_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rate_ok && rate_err));
  a_r10_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !rate_req |=> $stable(cur_level));
  a_r7_src_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && src_req && dyn_en |=> src_err);
endmodule

bind dvfs_level_ctrl dvfs_level_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rate_req(rate_req), .src_req(src_req),
  .cur_level(cur_level), .busy(busy), .dyn_en(dyn_en),
  .rate_ok(rate_ok), .rate_err(rate_err), .src_err(src_err)
);

// File: tb/dvfs_level_ctrl_test.sv
module dvfs_level_ctrl_test;
  localparam int CNT_W = 25;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic rate_req = 1'b0;
  logic [2:0] rate_div = '0;
  logic src_req = 1'b0;
  logic [1:0] src_val = '0;
  logic [CNT_W-1:0] settle_cycles = '0;
  logic [1:0] cur_level, clk_src;
  logic busy, dyn_en, clk_csel, rate_ok, rate_err, src_err;
  logic [2:0] clk_div;

  dvfs_level_ctrl #(.CNT_W(CNT_W)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_pair [2];
  logic m_dyn, m_scsel;
  logic [1:0] m_ssrc, m_lvl;
  logic [2:0] m_sdiv;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] half(int l);
    return (l % 2 == 0) ? m_pair[l/2][31:16] : m_pair[l/2][15:0];
  endfunction
  function automatic logic [15:0] mk(int s, int c, int d);
    return 16'((s & 3) << 9 | (c & 1) << 11 | (d & 7) << 13);
  endfunction

  task automatic check_out(string tag);
    logic [15:0] h = half(m_lvl);
    check({tag, " level"}, cur_level, m_lvl);
    check({tag, " dyn"}, dyn_en, m_dyn);
    check({tag, " src"}, clk_src, m_dyn ? h[10:9] : m_ssrc);
    check({tag, " csel"}, clk_csel, m_dyn ? h[11] : m_scsel);
    check({tag, " div"}, clk_div, m_dyn ? h[15:13] : m_sdiv);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    cfg_we = 0; rate_req = 0; src_req = 0;
  endtask

  task automatic cfg(int a, logic [31:0] d);
    cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = d;
    tick();
    case (a)
      0: m_pair[0] = d;
      1: m_pair[1] = d;
      2: m_dyn = d[31];
      default: begin m_ssrc = d[1:0]; m_sdiv = d[6:4]; m_scsel = d[8]; end
    endcase
    check_out("R2/R3 cfg");
  endtask

  task automatic src(int v);
    src_req = 1; src_val = 2'(v);
    tick();
    check("R7 src_err", src_err, m_dyn);
    if (!m_dyn) begin
      for (int p = 0; p < 2; p++) begin
        m_pair[p][10:9] = 2'(v);
        m_pair[p][26:25] = 2'(v);
      end
    end
    check_out("R6 src");
  endtask

  task automatic rate(int d, int s, bit inject);
    int hitl = -1;
    bit step;
    int cnt;
    for (int l = 3; l >= 0; l--) if (half(l)[15:13] == 3'(d)) hitl = l;
    rate_req = 1; rate_div = 3'(d); settle_cycles = CNT_W'(s);
    tick();
    if (!m_dyn || hitl < 0) begin
      check("R5 rate_err", rate_err, 1);
      check("R5 rate_ok", rate_ok, 0);
      check_out("R5 hold");
      return;
    end
    check("R4 rate_ok", rate_ok, 1);
    check("R4 rate_err", rate_err, 0);
    step = (hitl == 0) && (m_lvl >= 2);
    check("R10/R8 busy", busy, step);
    if (!step) begin
      m_lvl = 2'(hitl);
      check_out("R4 level");
      return;
    end
    m_lvl = 1;
    check_out("R8 step level");
    cnt = 1;
    while (busy) begin
      if (inject && cnt == 2) begin
        rate_req = 1; rate_div = half(3)[15:13]; src_req = 1; src_val = 2'd3;
      end
      tick();
      if (inject && cnt == 2) begin
        check("R9 rate_ok", rate_ok, 0);
        check("R9 rate_err", rate_err, 0);
        check("R9 src_err", src_err, 0);
      end
      if (busy) begin
        cnt++;
        check("R8 hold level1", cur_level, 1);
      end
    end
    check("R8 busy length", cnt, s + 1);
    m_lvl = 0;
    check_out("R8 final");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_pair[0] = 0; m_pair[1] = 0; m_dyn = 0; m_ssrc = 0; m_sdiv = 0; m_scsel = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_out("R1 reset");
    check("R1 busy", busy, 0);
    check("R1 pulses", {rate_ok, rate_err, src_err}, 0);

    cfg(0, {mk(2, 1, 1), mk(1, 0, 2)});
    cfg(1, {mk(3, 1, 4), mk(0, 0, 6)});
    cfg(3, 32'h0000_0153);           // R3 static fields: src 3, div 5, csel 1
    rate(2, 0, 0);                   // R5 rejected while scaling off
    src(1);                          // R6 broadcast
    cfg(2, 32'h8000_0000);           // R3 enable
    rate(6, 0, 0);                   // R4 -> level 3
    check("R6 slot3 src", clk_src, 1);
    rate(3, 0, 0);                   // R5 no match
    cfg(1, {mk(3, 1, 2), mk(0, 0, 6)});
    rate(2, 0, 0);                   // R4 first match is level 1
    check("R4 first match", cur_level, 1);
    rate(1, 0, 0);                   // R10 1 -> 0 direct
    rate(6, 0, 0);
    rate(1, 20, 1);                  // R8 stepped entry with R9 injection
    src(2);                          // R7 rejected
    rate(0, 0, 0);                   // R5 no slot has div 0 here
    rate(6, 0, 0);
    rate(1, 0, 0);                   // R8 zero settle

    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      if (op == 0) cfg($urandom_range(0, 1), $urandom);
      else if (op == 1) cfg(2, {$urandom_range(0, 3) != 0, 31'd0});
      else if (op == 2) cfg(3, $urandom);
      else if (op == 3) src($urandom_range(0, 3));
      else if (op < 8) rate(half($urandom_range(0, 3))[15:13], $urandom_range(0, 6), 0);
      else rate($urandom_range(0, 7), $urandom_range(0, 6), 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule